// File: doc/BRIEF.md
# Channel Mode, Interrupt and DMA Request Controller

This block keeps the local configuration state of one channel of a host-to-peripheral bus bridge. It turns channel events into a level interrupt request and a DMA request. The mode word holds three enables and an 11-bit count. The enables are DMA, automatic address stepping and the programmable bus timeout. The count gives the timeout length in bus clocks. The bus engine beside this block consumes the stepping enable, the timeout enable and the count.

A second word, the status word, has two byte lanes. The low lane holds three interrupt masks and can be read and written. One of those masks is a master gate that silences the interrupt line without changing the other two masks. The high lane reports two pending flags. The first flag records that the host signalled end of a DMA block for this channel. The second records that a transfer on the external bus timed out. Any access to the high lane, read or write, clears both flags, and data written to that lane is discarded.

Software starts a DMA burst by setting the DMA enable in the mode word. The request then stays high until the host acknowledges it.

Top module: `chan_irq_dma_ctl`

## Requirements
- R1: After reset, the mode word and the status word both read 0, and `irq` and `dma_req` are low.
- R2: A write with `reg_sel`=0 stores `wdata[13:0]` as the mode word. Its fields are bit0 = DMA enable, bit1 = address-step enable (`incr_en`), bit2 = programmable-timeout enable (`sw_delay_en`) and bits 13:3 = timeout count (`soft_timeout`). A read returns the stored value, with bits 15:14 reading 0.
- R3: A mode write with bit0=1 raises `dma_req` on the next clock. The request stays high until a cycle in which `host_dack` is high, and it drops at that clock edge. A mode write with bit0=0 drops the request.
- R4: The DMA flag (status bit8) is set when `host_tc` and `host_dack` are both high while the DMA enable is 1. `host_tc` without `host_dack` has no effect.
- R5: A cycle with `timeout_evt` high sets the timeout flag (status bit9).
- R6: With `reg_sel`=1 and `reg_be[0]`=1, a write stores `wdata[2:0]` into the low status lane. Bit0 is the master enable, bit1 the DMA interrupt mask and bit2 the timeout interrupt mask. Status bits 7:3 read 0.
- R7: `irq` = master AND ((DMA flag AND DMA mask) OR (timeout flag AND timeout mask)).
- R8: Clearing the master enable leaves the two individual masks unchanged in readback.
- R9: Any read or write with `reg_sel`=1 and `reg_be[1]`=1 clears both flags on that clock edge. The data written to the high lane is not stored.
- R10: A flag event in the same cycle as a clearing access leaves that flag set.
- R11: A read of the high status lane returns the flag values as they stood before that access cleared them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_sel | input | 1 | 0 selects the mode word, 1 selects the status word |
| reg_be | input | 2 | Byte lane enables for status accesses (bit0 low lane, bit1 high lane) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected word (combinational) |
| timeout_evt | input | 1 | External transfer timed out |
| host_tc | input | 1 | Host terminal count |
| host_dack | input | 1 | Host DMA acknowledge for this channel |
| incr_en | output | 1 | Address-step enable from the mode word |
| sw_delay_en | output | 1 | Programmable-timeout enable from the mode word |
| soft_timeout | output | 11 | Programmed timeout count |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The assertions check on every clock cycle the following rules:
- an acknowledge drops the DMA request, and without one the request holds;
- a timeout event always leaves its flag set;
- a terminal count without an acknowledge never sets the DMA flag;
- a clearing access with no coincident event empties both flags;
- the masks move only on a low-lane write;
- the master gate keeps `irq` low.

Some behaviour shows only in the bench's scenarios. These are:
- the full interrupt equation across mask and flag combinations;
- the readback of mode fields and unused bits;
- read data taken just before a clear;
- an event that lands in the same cycle as a clear.

// File: rtl/chan_irq_dma_ctl.sv
module chan_irq_dma_ctl #(
  parameter int TMO_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_sel,
  input  logic [1:0]       reg_be,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  input  logic             timeout_evt,
  input  logic             host_tc,
  input  logic             host_dack,
  output logic             incr_en,
  output logic             sw_delay_en,
  output logic [TMO_W-1:0] soft_timeout,
  output logic             irq,
  output logic             dma_req
);
  localparam int MODE_W = TMO_W + 3;

  logic [MODE_W-1:0] mode_q;
  logic [2:0]        mask_q;
  logic [1:0]        flag_q;
  logic              req_q;

  logic mode_wr, mask_wr, flag_clr, dma_set, tmo_set;

  assign mode_wr  = reg_wr && !reg_sel;
  assign mask_wr  = reg_wr && reg_sel && reg_be[0];
  assign flag_clr = (reg_wr || reg_rd) && reg_sel && reg_be[1];
  assign dma_set  = host_tc && host_dack && mode_q[0];
  assign tmo_set  = timeout_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
      req_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= wdata[MODE_W-1:0];
      if (mask_wr) mask_q <= wdata[2:0];
      flag_q[0] <= dma_set || (flag_q[0] && !flag_clr);
      flag_q[1] <= tmo_set || (flag_q[1] && !flag_clr);
      if (mode_wr)        req_q <= wdata[0];
      else if (host_dack) req_q <= 1'b0;
    end
  end

  assign rdata = reg_sel ? {6'b0, flag_q, 5'b0, mask_q}
                         : {{(16-MODE_W){1'b0}}, mode_q};

  assign incr_en      = mode_q[1];
  assign sw_delay_en  = mode_q[2];
  assign soft_timeout = mode_q[MODE_W-1:3];
  assign dma_req      = req_q;
  assign irq = mask_q[0] && ((flag_q[0] && mask_q[1]) || (flag_q[1] && mask_q[2]));
endmodule

// File: rtl/chan_irq_dma_ctl_chk.sv
module chan_irq_dma_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       reg_sel,
  input logic [1:0] reg_be,
  input logic       timeout_evt,
  input logic       host_tc,
  input logic       host_dack,
  input logic       irq,
  input logic       dma_req,
  input logic [2:0] mask,
  input logic [1:0] flags
);
  logic mwr, clr;
  assign mwr = reg_wr && !reg_sel;
  assign clr = (reg_wr || reg_rd) && reg_sel && reg_be[1];

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!irq && !dma_req && flags == 2'b00));

  a_r3_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dack && !mwr) |=> !dma_req);

  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !host_dack && !mwr) |=> dma_req);

  a_r4_tc_needs_dack: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[0] && !host_dack) |=> !flags[0]);

  a_r5_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> flags[1]);

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !timeout_evt && !(host_tc && host_dack)) |=> flags == 2'b00);

  a_r8_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel && reg_be[0]) |=> $stable(mask));

  a_r7_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[0] |-> !irq);
endmodule

bind chan_irq_dma_ctl chan_irq_dma_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_sel(reg_sel), .reg_be(reg_be), .timeout_evt(timeout_evt),
  .host_tc(host_tc), .host_dack(host_dack), .irq(irq), .dma_req(dma_req),
  .mask(mask_q), .flags(flag_q)
);

// File: tb/sim_chan_irq_dma_ctl.sv
`timescale 1ns/1ps
module sim_chan_irq_dma_ctl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [1:0] reg_be = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic timeout_evt = 0, host_tc = 0, host_dack = 0;
  logic incr_en, sw_delay_en, irq, dma_req;
  logic [10:0] soft_timeout;

  int n_chk = 0, n_bad = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  chan_irq_dma_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_be(reg_be), .wdata(wdata), .rdata(rdata),
    .timeout_evt(timeout_evt), .host_tc(host_tc), .host_dack(host_dack),
    .incr_en(incr_en), .sw_delay_en(sw_delay_en), .soft_timeout(soft_timeout),
    .irq(irq), .dma_req(dma_req)
  );

  // {mask[2:0], dma_flag, tmo_flag, expected irq}
  localparam logic [5:0] VEC [10] = '{
    6'b000_11_0, 6'b001_11_0, 6'b011_10_1, 6'b011_01_0, 6'b101_01_1,
    6'b101_10_0, 6'b111_11_1, 6'b110_11_0, 6'b111_00_0, 6'b010_10_0
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_be = be; wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_be = 0; wdata = 0;
  endtask

  task automatic rd(input logic sel, input logic [1:0] be, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1; reg_sel = sel; reg_be = be;
    #1 d = rdata;
    @(negedge clk);
    reg_rd = 0; reg_be = 0;
  endtask

  task automatic pulse(input logic t, input logic tc, input logic ack);
    @(negedge clk);
    timeout_evt = t; host_tc = tc; host_dack = ack;
    @(negedge clk);
    timeout_evt = 0; host_tc = 0; host_dack = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk({14'b0, irq, dma_req}, 16'h0, "R1 irq/dma_req");
    rd(0, 2'b00, rv); chk(rv, 16'h0, "R1 mode");
    rd(1, 2'b01, rv); chk(rv, 16'h0, "R1 status");

    // R2
    wr(0, 2'b11, {2'b11, 11'h5A3, 3'b110});
    chk({4'b0, incr_en, sw_delay_en, soft_timeout[9:0]}, {4'b0, 1'b1, 1'b1, 10'h1A3}, "R2 fields");
    chk({15'b0, soft_timeout[10]}, 16'h1, "R2 count msb");
    rd(0, 2'b00, rv); chk(rv, {2'b00, 11'h5A3, 3'b110}, "R2 readback");
    chk({15'b0, dma_req}, 16'h0, "R3 no req without enable");

    // R3
    wr(0, 2'b11, 16'h0001);
    chk({15'b0, dma_req}, 16'h1, "R3 req raised");
    repeat (3) @(negedge clk);
    chk({15'b0, dma_req}, 16'h1, "R3 req held");
    pulse(0, 0, 1);
    chk({15'b0, dma_req}, 16'h0, "R3 req dropped by ack");
    wr(0, 2'b11, 16'h0001);
    wr(0, 2'b11, 16'h0000);
    chk({15'b0, dma_req}, 16'h0, "R3 req dropped by disable");

    // R4
    wr(0, 2'b11, 16'h0001);
    pulse(0, 1, 0);
    rd(1, 2'b01, rv); chk(rv, 16'h0, "R4 tc without dack ignored");
    pulse(0, 1, 1);
    rd(1, 2'b01, rv); chk(rv, 16'h0100, "R4 dma flag set");
    // R11 + R9: read of high lane returns flags, then they are gone
    rd(1, 2'b10, rv); chk(rv, 16'h0100, "R11 read before clear");
    rd(1, 2'b01, rv); chk(rv, 16'h0, "R9 cleared by read");

    // R5
    pulse(1, 0, 0);
    rd(1, 2'b01, rv); chk(rv, 16'h0200, "R5 timeout flag");

    // R6
    wr(1, 2'b01, 16'h00FF);
    rd(1, 2'b01, rv); chk(rv, 16'h0207, "R6 mask bits only");

    // R9: write to high lane clears flags, stores nothing, masks untouched
    wr(1, 2'b10, 16'hFFFF);
    rd(1, 2'b01, rv); chk(rv, 16'h0007, "R9 write clears, data dropped");

    // R7 vector table (DMA enable kept on in mode)
    wr(0, 2'b11, 16'h0001);
    for (int i = 0; i < 10; i++) begin
      rd(1, 2'b10, rv);
      wr(1, 2'b01, {13'b0, VEC[i][5:3]});
      if (VEC[i][2]) pulse(0, 1, 1);
      if (VEC[i][1]) pulse(1, 0, 0);
      chk({15'b0, irq}, {15'b0, VEC[i][0]}, $sformatf("R7 vector %0d", i));
    end

    // R8
    wr(1, 2'b01, 16'h0006);
    rd(1, 2'b01, rv); chk(rv & 16'h00FF, 16'h0006, "R8 masks kept with master off");
    wr(1, 2'b01, 16'h0007);
    chk({15'b0, irq}, 16'h1, "R8 irq returns with master on");

    // R10: event in the same cycle as a clearing read
    rd(1, 2'b10, rv);
    @(negedge clk);
    reg_rd = 1; reg_sel = 1; reg_be = 2'b10; timeout_evt = 1;
    @(negedge clk);
    reg_rd = 0; reg_be = 0; timeout_evt = 0;
    rd(1, 2'b01, rv); chk(rv, 16'h0207, "R10 coincident event kept");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule